// File: doc/BRIEF.md
# USB device address filter

This block keeps the address a USB device answers to and decides, for every decoded token, whether the token is meant for this device. Firmware sets the address in two writes. The first write stores the 7-bit address field with the enable bit clear. The second write repeats the same address with the enable bit set. Until that second write lands, the device keeps answering to the default address 0. This lets the status stage of the address-assignment request finish on address 0.

Both the address field and the enable bit drop back to zero on any of three events: the asynchronous hardware reset, a low level on the macro enable input, or a detected bus reset. A token decoder outside the block supplies the token's address field and a one-cycle valid strobe. The block returns a registered accept flag one clock later. A register read port always shows the stored field and the enable bit.

Top module: `usb_addr_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rd_addr` is 0, `rd_enable` is 0 and `tok_accept` is 0.
- R2: A clock edge with `macro_en` low clears the stored address and the enable bit. `tok_accept` is 0 after that edge.
- R3: A clock edge with `bus_rst` high clears the stored address and the enable bit. `tok_accept` is 0 after that edge.
- R4: The effective address is the stored address when the enable bit is 1, and 0 otherwise. A token is accepted only if its 7-bit address equals the effective address.
- R5: A write (`wr_en` high) with `wr_addr_en` = 0 stores `wr_addr` and clears the enable bit. Afterwards tokens to address 0 are accepted and tokens to the newly written nonzero address are not.
- R6: A write with `wr_addr_en` = 1 whose `wr_addr` equals the address already stored sets the enable bit.
- R7: A write with `wr_addr_en` = 1 whose `wr_addr` differs from the stored address stores the new address and leaves the enable bit 0. The enable request of that write is ignored.
- R8: `tok_accept` is registered. It is 1 in the cycle after a clock edge at which `tok_valid` was 1 and the address matched. It is 0 after any edge at which `tok_valid` was 0.
- R9: `rd_addr` and `rd_enable` show the stored address field and the enable bit after every edge.
- R10: A token and a write at the same edge: the token is judged against the state as it was before that write.
- R11: A write at an edge where `macro_en` is low or `bus_rst` is high is discarded. A token at that edge is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| macro_en | input | 1 | Macro enable; low clears the address state |
| bus_rst | input | 1 | Detected USB bus reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Address field written |
| wr_addr_en | input | 1 | Enable bit written |
| rd_addr | output | 7 | Stored address field readback |
| rd_enable | output | 1 | Stored enable bit readback |
| tok_valid | input | 1 | Token valid strobe |
| tok_addr | input | 7 | Address field of the token |
| tok_accept | output | 1 | Token accepted, one cycle after the strobe |

## Verification
A firmware write and a token can arrive at the same clock edge. A reset condition can also coincide with both of them. The bench provokes these collisions in two ways: directed steps where the write flips the enable bit while a token targets either the old or the new effective address, and random traffic that often aims tokens at address 0 or at the stored address. Each result is judged against a reference model in the bench. That model evaluates the token against the state before the edge and only then applies the write or the clear.

// File: rtl/usb_addr_filter.sv
module usb_addr_filter #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              macro_en,
  input  logic              bus_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_addr_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_enable,
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  output logic              tok_accept
);

  logic [ADDR_W-1:0] dev_addr;
  logic              addr_on;
  logic              clr;
  logic [ADDR_W-1:0] eff_addr;

  assign clr      = !macro_en || bus_rst;
  assign eff_addr = addr_on ? dev_addr : '0;
  assign rd_addr  = dev_addr;
  assign rd_enable = addr_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr <= '0;
      addr_on  <= 1'b0;
    end else if (clr) begin
      dev_addr <= '0;
      addr_on  <= 1'b0;
    end else if (wr_en) begin
      dev_addr <= wr_addr;
      addr_on  <= wr_addr_en && (wr_addr == dev_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_accept <= 1'b0;
    else        tok_accept <= !clr && tok_valid && (tok_addr == eff_addr);
  end

  // R2
  clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!macro_en || bus_rst) |=> (rd_addr == '0 && !rd_enable && !tok_accept));

  // R8
  accept_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_accept |-> $past(tok_valid));

  // R4
  accept_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_accept |-> ($past(tok_addr) == ($past(rd_enable) ? $past(rd_addr) : '0)));

  // R6
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_enable) |-> $past(wr_en && wr_addr_en && wr_addr == rd_addr));

  // R7
  diff_addr_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr_en && wr_addr != rd_addr) |=> !rd_enable);

endmodule

// File: tb/test_usb_addr_filter.sv
module test_usb_addr_filter;
  logic clk = 0, rst_n = 0, macro_en = 1, bus_rst = 0;
  logic wr_en = 0, wr_addr_en = 0, tok_valid = 0;
  logic [6:0] wr_addr = 0, tok_addr = 0;
  logic [6:0] rd_addr;
  logic rd_enable, tok_accept;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [6:0] m_addr = 0;
  bit m_en = 0;
  bit exp_acc = 0;

  always #5 clk = ~clk;

  usb_addr_filter i_usb_addr_filter (
    .clk(clk), .rst_n(rst_n), .macro_en(macro_en), .bus_rst(bus_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_addr_en(wr_addr_en),
    .rd_addr(rd_addr), .rd_enable(rd_enable),
    .tok_valid(tok_valid), .tok_addr(tok_addr), .tok_accept(tok_accept));

  function automatic logic [6:0] eff(logic [6:0] a, bit e);
    return e ? a : 7'd0;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit me, bit br, bit we, logic [6:0] wa, bit wen, bit tv, logic [6:0] ta,
                      string tag);
    macro_en = me; bus_rst = br; wr_en = we; wr_addr = wa; wr_addr_en = wen;
    tok_valid = tv; tok_addr = ta;
    exp_acc = me && !br && tv && (ta == eff(m_addr, m_en));
    if (!me || br) begin m_addr = 0; m_en = 0; end
    else if (we) begin m_en = wen && (wa == m_addr); m_addr = wa; end
    @(posedge clk);
    @(negedge clk);
    check({tag, " accept"}, tok_accept, exp_acc);
    check("R9 rd_addr", rd_addr, m_addr);
    check("R9 rd_enable", rd_enable, m_en);
  endtask

  task automatic idle_tok(logic [6:0] ta, string tag);
    step(1, 0, 0, 0, 0, 1, ta, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 rd_addr", rd_addr, 0);
    check("R1 rd_enable", rd_enable, 0);
    check("R1 accept", tok_accept, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 accept after release", tok_accept, 0);
    idle_tok(0, "R4 default addr");
    idle_tok(5, "R4 foreign addr");
    step(1, 0, 1, 7'd42, 0, 0, 0, "R5");
    idle_tok(42, "R5 not yet");
    idle_tok(0, "R5 still zero");
    step(1, 0, 0, 0, 0, 0, 0, "R8 no strobe");
    step(1, 0, 1, 7'd42, 1, 1, 0, "R10 old state zero");
    check("R6 enabled", rd_enable, 1);
    idle_tok(42, "R4 enabled match");
    idle_tok(0, "R4 zero rejected");
    step(1, 0, 1, 7'd17, 1, 1, 42, "R10 old addr");
    check("R7 enable ignored", rd_enable, 0);
    idle_tok(17, "R7 new addr rejected");
    idle_tok(0, "R7 zero accepted");
    step(1, 0, 1, 7'd17, 1, 0, 0, "R6");
    step(1, 1, 1, 7'd17, 1, 1, 17, "R11 bus reset");
    check("R3 cleared", rd_addr, 0);
    idle_tok(0, "R3 zero after reset");
    step(1, 0, 1, 7'd9, 0, 0, 0, "R5");
    step(1, 0, 1, 7'd9, 1, 0, 0, "R6");
    step(0, 0, 1, 7'd9, 1, 1, 9, "R11 macro off");
    check("R2 cleared", rd_enable, 0);
    step(1, 0, 1, 7'd0, 0, 0, 0, "R5");
    step(1, 0, 1, 7'd0, 1, 1, 0, "R6 zero addr");
    idle_tok(0, "R4 enabled zero");
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 99);
      logic [6:0] a, t;
      case ($urandom_range(0, 2))
        0: a = m_addr;
        1: a = 7'($urandom_range(0, 3));
        default: a = 7'($urandom);
      endcase
      case ($urandom_range(0, 2))
        0: t = eff(m_addr, m_en);
        1: t = m_addr;
        default: t = 7'($urandom_range(0, 3));
      endcase
      if (r == 0) begin
        rst_n = 0;
        m_addr = 0; m_en = 0;
        @(negedge clk);
        check("R1 mid reset", rd_addr + rd_enable + tok_accept, 0);
        rst_n = 1;
        @(negedge clk);
      end else begin
        step(r > 3, r < 6, $urandom_range(0, 2) == 0, a, $urandom_range(0, 1) == 1,
             $urandom_range(0, 1) == 1, t, "R4/R10 random");
      end
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule